// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block is a fully associative address translation buffer for 32-bit virtual addresses. Every entry describes a pair of neighbouring pages, an even one and an odd one, that share a single tag but keep their own frame address, valid flag and dirty flag. A per-entry page mask widens the pages beyond the 4 KB minimum, so one tag can cover a pair of 8 KB, 32 KB, 128 KB or larger pages.

Software fills entries through a write port: it gives an index and all fields of the entry, and the whole entry is stored on one clock edge. A lookup presents a virtual address, the current 8-bit address-space tag and a flag that marks the access as a write. Every entry is compared in parallel in the same cycle. On the next clock edge the block returns a result code, a physical address and a write-permission flag. An entry whose global flag is set matches under any address-space tag.

Top module: `tlbp_unit`

## Requirements
- R1: An entry hits when its global flag is set or its stored address-space tag equals `lk_asid`, and `lk_va` equals the stored virtual page number in every bit outside the effective mask.
- R2: The effective mask is `wr_pmask` OR 0x00001FFF. Each page is at least 4 KB and each pair is at least 8 KB, and a set page-mask bit widens both pages.
- R3: The half is chosen by the address bit at the highest set position of the effective mask (bit 12 for the smallest pages). A 0 there selects frame 0, valid 0 and dirty 0. A 1 selects frame 1, valid 1 and dirty 1. The half-offset mask is the effective mask shifted right by one.
- R4: A hit whose selected half has its valid flag clear returns code 2 (invalid), with `rsp_pa` = 0 and `rsp_wperm` = 0.
- R5: A hit on a valid half, for a read or for a write to a dirty half, returns code 0 (match). `rsp_pa` is the selected frame OR (`lk_va` AND half-offset mask), and `rsp_wperm` equals the dirty flag of that half.
- R6: A write to a hit, valid, clean half returns code 3 (modified), with `rsp_pa` = 0 and `rsp_wperm` = 0.
- R7: When no entry hits, the block returns code 1 (no-match), with `rsp_pa` = 0 and `rsp_wperm` = 0.
- R8: When several entries hit, the lowest-indexed one decides the result. Multiple hits raise no error.
- R9: A write with `wr_en` stores every field of entry `wr_idx` on one clock edge. A lookup requested in one cycle is answered with `rsp_valid` = 1 after the next rising edge, and `rsp_valid` is 0 in a cycle that follows no request.
- R10: Synchronous active-high reset clears every valid flag and every stored field. After reset no lookup returns code 0, and `rsp_valid` is 0.
- R11: A lookup made in the same cycle as a write to the entry array sees the entries as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store an entry this cycle |
| wr_idx | input | IDX_W | Index of the entry to store |
| wr_pmask | input | 32 | Page mask of the entry |
| wr_vpn | input | 32 | Virtual page-pair address of the entry |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_global | input | 1 | Entry matches under every address-space tag |
| wr_frame0 | input | 32 | Physical frame of the even page |
| wr_frame1 | input | 32 | Physical frame of the odd page |
| wr_valid0 | input | 1 | Even page valid |
| wr_valid1 | input | 1 | Odd page valid |
| wr_dirty0 | input | 1 | Even page writable |
| wr_dirty1 | input | 1 | Odd page writable |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_write | input | 1 | The access is a write |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_code | output | 2 | 0 match, 1 no-match, 2 invalid, 3 modified |
| rsp_pa | output | 32 | Translated physical address (0 unless the code is match) |
| rsp_wperm | output | 1 | The translated page may be written |

## Verification
A write to the entry array and a lookup can fall in the same cycle. The bench provokes this by storing a new entry at an index while a lookup is issued for the address that entry will cover. The response must come from the old contents: no-match, or the older entry that still hits. A lookup for the same address in the next cycle must return the new translation. The behavioural reference model resolves each cycle's lookup before it applies that cycle's write, and the bench compares the design against it on every clock.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

    localparam int VA_W       = 32;
    localparam int ASID_W     = 8;
    localparam int PAGE_SHIFT = 12;

    typedef logic [VA_W-1:0]   addr_t;
    typedef logic [ASID_W-1:0] asid_t;

    localparam addr_t PAIR_LOW = (addr_t'(1) << (PAGE_SHIFT + 1)) - addr_t'(1);

    typedef enum logic [1:0] {
        RES_MATCH    = 2'd0,
        RES_NOMATCH  = 2'd1,
        RES_INVALID  = 2'd2,
        RES_MODIFIED = 2'd3
    } tlb_res_e;

    typedef struct packed {
        addr_t pmask;
        addr_t vpn;
        asid_t asid;
        logic  glob;
        addr_t frame0;
        addr_t frame1;
        logic  v0;
        logic  v1;
        logic  d0;
        logic  d1;
    } tlb_entry_t;

    function automatic addr_t eff_mask(input addr_t pm);
        return pm | PAIR_LOW;
    endfunction

    function automatic logic odd_half(input addr_t m, input addr_t va);
        return |(va & m & ~(m >> 1));
    endfunction

endpackage

// File: rtl/tlbp_store.sv
module tlbp_store
    import tlbp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  tlb_entry_t       wentry,
    output tlb_entry_t       ents [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (we && widx == IDX_W'(g)) begin
                ents[g] <= wentry;
            end
        end
    end

endmodule

// File: rtl/tlbp_match.sv
module tlbp_match
    import tlbp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  tlb_entry_t ents [DEPTH],
    input  addr_t      va,
    input  asid_t      asid,
    output logic       hit_any,
    output tlb_entry_t hit_ent
);

    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        addr_t m;
        assign m      = eff_mask(ents[g].pmask);
        assign hit[g] = (ents[g].glob || ents[g].asid == asid) &&
                        ((ents[g].vpn & ~m) == (va & ~m));
    end

    always_comb begin
        hit_ent = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) hit_ent = ents[i];
        end
    end

    assign hit_any = |hit;

endmodule

// File: rtl/tlbp_resolve.sv
module tlbp_resolve
    import tlbp_pkg::*;
(
    input  logic       hit_any,
    input  tlb_entry_t ent,
    input  addr_t      va,
    input  logic       is_write,
    output tlb_res_e   code,
    output addr_t      pa,
    output logic       wperm
);

    addr_t m;
    logic  odd, hv, hd;
    addr_t frame;

    always_comb begin
        m     = eff_mask(ent.pmask);
        odd   = odd_half(m, va);
        hv    = odd ? ent.v1 : ent.v0;
        hd    = odd ? ent.d1 : ent.d0;
        frame = odd ? ent.frame1 : ent.frame0;
        code  = RES_NOMATCH;
        pa    = '0;
        wperm = 1'b0;
        if (hit_any) begin
            if (!hv) begin
                code = RES_INVALID;
            end else if (is_write && !hd) begin
                code = RES_MODIFIED;
            end else begin
                code  = RES_MATCH;
                pa    = frame | (va & (m >> 1));
                wperm = hd;
            end
        end
    end

endmodule

// File: rtl/tlbp_unit.sv
module tlbp_unit
    import tlbp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_pmask,
    input  logic [31:0]      wr_vpn,
    input  logic [7:0]       wr_asid,
    input  logic             wr_global,
    input  logic [31:0]      wr_frame0,
    input  logic [31:0]      wr_frame1,
    input  logic             wr_valid0,
    input  logic             wr_valid1,
    input  logic             wr_dirty0,
    input  logic             wr_dirty1,
    input  logic             lk_req,
    input  logic [31:0]      lk_va,
    input  logic [7:0]       lk_asid,
    input  logic             lk_write,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [31:0]      rsp_pa,
    output logic             rsp_wperm
);

    tlb_entry_t wentry;
    tlb_entry_t ents [DEPTH];
    tlb_entry_t hit_ent;
    logic       hit_any;
    tlb_res_e   code_c;
    addr_t      pa_c;
    logic       wperm_c;

    always_comb begin
        wentry.pmask  = wr_pmask;
        wentry.vpn    = wr_vpn;
        wentry.asid   = wr_asid;
        wentry.glob   = wr_global;
        wentry.frame0 = wr_frame0;
        wentry.frame1 = wr_frame1;
        wentry.v0     = wr_valid0;
        wentry.v1     = wr_valid1;
        wentry.d0     = wr_dirty0;
        wentry.d1     = wr_dirty1;
    end

    tlbp_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en),
        .widx   (wr_idx),
        .wentry (wentry),
        .ents   (ents)
    );

    tlbp_match #(.DEPTH(DEPTH)) u_match (
        .ents    (ents),
        .va      (lk_va),
        .asid    (lk_asid),
        .hit_any (hit_any),
        .hit_ent (hit_ent)
    );

    tlbp_resolve u_resolve (
        .hit_any  (hit_any),
        .ent      (hit_ent),
        .va       (lk_va),
        .is_write (lk_write),
        .code     (code_c),
        .pa       (pa_c),
        .wperm    (wperm_c)
    );

    always_ff @(posedge clk) begin
        if (rst || !lk_req) begin
            rsp_valid <= 1'b0;
            rsp_code  <= RES_NOMATCH;
            rsp_pa    <= '0;
            rsp_wperm <= 1'b0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_code  <= code_c;
            rsp_pa    <= pa_c;
            rsp_wperm <= wperm_c;
        end
    end

endmodule

// File: rtl/tlbp_checker.sv
module tlbp_checker (
    input logic        clk,
    input logic        rst,
    input logic        lk_req,
    input logic        lk_write,
    input logic        rsp_valid,
    input logic [1:0]  rsp_code,
    input logic [31:0] rsp_pa,
    input logic        rsp_wperm
);

    a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    a_r9_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid);

    a_r6_fault_has_no_pa: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_pa == 32'd0 && !rsp_wperm));

    a_r5_write_match_is_writable: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_write) |=> (rsp_code == 2'd0) == (rsp_valid && rsp_wperm && rsp_code == 2'd0));

    a_r10_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid);

endmodule

bind tlbp_unit tlbp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .lk_write  (lk_write),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_pa    (rsp_pa),
    .rsp_wperm (rsp_wperm)
);

// File: tb/tlbp_unit_test.sv
module tlbp_unit_test;

    localparam int DEPTH = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [31:0]      wr_pmask = '0, wr_vpn = '0, wr_frame0 = '0, wr_frame1 = '0;
    logic [7:0]       wr_asid = '0;
    logic             wr_global = 1'b0;
    logic             wr_valid0 = 1'b0, wr_valid1 = 1'b0, wr_dirty0 = 1'b0, wr_dirty1 = 1'b0;
    logic             lk_req = 1'b0;
    logic [31:0]      lk_va = '0;
    logic [7:0]       lk_asid = '0;
    logic             lk_write = 1'b0;
    logic             rsp_valid;
    logic [1:0]       rsp_code;
    logic [31:0]      rsp_pa;
    logic             rsp_wperm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    tlbp_unit #(.DEPTH(DEPTH)) uut (.*);

    always #5 clk = ~clk;

    // behavioural reference state
    logic [31:0] m_pmask [DEPTH];
    logic [31:0] m_vpn   [DEPTH];
    logic [31:0] m_f0    [DEPTH];
    logic [31:0] m_f1    [DEPTH];
    logic [7:0]  m_asid  [DEPTH];
    bit          m_g [DEPTH], m_v0 [DEPTH], m_v1 [DEPTH], m_d0 [DEPTH], m_d1 [DEPTH];

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            m_pmask[i] = 0; m_vpn[i] = 0; m_f0[i] = 0; m_f1[i] = 0; m_asid[i] = 0;
            m_g[i] = 0; m_v0[i] = 0; m_v1[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
        end
    endtask

    task automatic model_lookup(input logic [31:0] va, input logic [7:0] asid, input bit w,
                                output int code, output logic [31:0] pa, output bit wp);
        code = 1; pa = 0; wp = 0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [31:0] m;
            bit odd;
            m = m_pmask[i] | 32'h0000_1FFF;
            if ((m_g[i] || m_asid[i] == asid) && ((m_vpn[i] & ~m) == (va & ~m))) begin
                odd = ((va & (m ^ (m >> 1))) != 0);
                if (!(odd ? m_v1[i] : m_v0[i])) code = 2;
                else if (w && !(odd ? m_d1[i] : m_d0[i])) code = 3;
                else begin
                    code = 0;
                    pa = (odd ? m_f1[i] : m_f0[i]) | (va & (m >> 1));
                    wp = odd ? m_d1[i] : m_d0[i];
                end
                break;
            end
        end
    endtask

    // one clock: predict from inputs now, apply model write, compare at next negedge
    task automatic tick(input string tag);
        int exp_code;
        logic [31:0] exp_pa;
        bit exp_wp, exp_v;
        exp_v = lk_req && !rst;
        model_lookup(lk_va, lk_asid, lk_write, exp_code, exp_pa, exp_wp);
        if (rst) model_clear();
        else if (wr_en) begin
            m_pmask[wr_idx] = wr_pmask; m_vpn[wr_idx] = wr_vpn; m_asid[wr_idx] = wr_asid;
            m_g[wr_idx] = wr_global; m_f0[wr_idx] = wr_frame0; m_f1[wr_idx] = wr_frame1;
            m_v0[wr_idx] = wr_valid0; m_v1[wr_idx] = wr_valid1;
            m_d0[wr_idx] = wr_dirty0; m_d1[wr_idx] = wr_dirty1;
        end
        @(negedge clk);
        checks++;
        if (rsp_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: rsp_valid=%0b expected %0b", tag, rsp_valid, exp_v);
        end else if (exp_v && (rsp_code !== 2'(exp_code) || rsp_pa !== exp_pa || rsp_wperm !== exp_wp)) begin
            errors++;
            $display("FAIL %s: va=%h code=%0d pa=%h wp=%0b expected code=%0d pa=%h wp=%0b",
                     tag, lk_va, rsp_code, rsp_pa, rsp_wperm, exp_code, exp_pa, exp_wp);
        end
    endtask

    task automatic put(input int idx, input logic [31:0] pm, input logic [31:0] vpn,
                       input logic [7:0] asid, input bit g, input logic [31:0] f0,
                       input logic [31:0] f1, input bit v0, input bit v1, input bit d0, input bit d1);
        wr_en = 1; wr_idx = IDX_W'(idx); wr_pmask = pm; wr_vpn = vpn; wr_asid = asid;
        wr_global = g; wr_frame0 = f0; wr_frame1 = f1;
        wr_valid0 = v0; wr_valid1 = v1; wr_dirty0 = d0; wr_dirty1 = d1;
        tick("R9 write");
        wr_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] asid, input bit w, input string tag);
        lk_req = 1; lk_va = va; lk_asid = asid; lk_write = w;
        tick(tag);
        lk_req = 0; lk_write = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        @(negedge clk);
        tick("R10 reset"); tick("R10 reset");
        rst = 0;
        tick("R10 idle after reset");
        look(32'h0000_0000, 8'd0, 0, "R10 cleared entry is invalid");
        look(32'h1234_5000, 8'd3, 0, "R7 empty array");

        put(3, 32'h0, 32'h0040_0000, 8'd5, 0, 32'h1000_0000, 32'h2000_0000, 1, 1, 1, 0);
        look(32'h0040_0123, 8'd5, 0, "R5 even read");
        look(32'h0040_1456, 8'd5, 0, "R3 odd read");
        look(32'h0040_1456, 8'd5, 1, "R6 write to clean odd");
        look(32'h0040_0FFC, 8'd5, 1, "R5 write to dirty even");
        look(32'h0040_0123, 8'd6, 0, "R1 R7 other tag");
        look(32'h0040_2000, 8'd5, 0, "R7 next pair");

        put(5, 32'h0, 32'h8000_0000, 8'd9, 1, 32'h0500_0000, 32'h0600_0000, 1, 1, 0, 1);
        look(32'h8000_1010, 8'd2, 1, "R1 global ignores tag");
        look(32'h8000_0010, 8'd7, 0, "R1 global even");

        put(7, 32'h0001_E000, 32'h0100_0000, 8'd5, 0, 32'h3100_0000, 32'h3000_0000, 1, 1, 1, 1);
        look(32'h0101_0ABC, 8'd5, 0, "R2 R3 wide odd");
        look(32'h0100_FFFF, 8'd5, 1, "R2 wide even top");
        look(32'h0102_0000, 8'd5, 0, "R2 R7 past wide pair");

        put(9, 32'h0, 32'h0050_0000, 8'd5, 0, 32'h4000_0000, 32'h4100_0000, 0, 1, 1, 1);
        look(32'h0050_0008, 8'd5, 0, "R4 invalid even");
        look(32'h0050_0008, 8'd5, 1, "R4 invalid even write");
        look(32'h0050_1008, 8'd5, 1, "R5 valid odd write");

        put(10, 32'h0, 32'h0060_0000, 8'd1, 0, 32'h5000_0000, 32'h5100_0000, 1, 1, 1, 1);
        put(11, 32'h0, 32'h0060_0000, 8'd1, 0, 32'h6000_0000, 32'h6100_0000, 1, 1, 0, 0);
        look(32'h0060_0044, 8'd1, 1, "R8 lower index wins");
        put(2, 32'h0, 32'h0060_0000, 8'd1, 0, 32'h7000_0000, 32'h7100_0000, 0, 0, 0, 0);
        look(32'h0060_0044, 8'd1, 0, "R8 new lowest index wins");

        // same cycle write and lookup
        wr_en = 1; wr_idx = 4'd12; wr_pmask = 0; wr_vpn = 32'h0070_0000; wr_asid = 8'd5;
        wr_global = 0; wr_frame0 = 32'h0A00_0000; wr_frame1 = 32'h0B00_0000;
        wr_valid0 = 1; wr_valid1 = 1; wr_dirty0 = 1; wr_dirty1 = 1;
        lk_req = 1; lk_va = 32'h0070_0100; lk_asid = 8'd5; lk_write = 0;
        tick("R11 lookup sees old contents");
        wr_en = 0;
        tick("R11 lookup sees new entry");
        wr_en = 1; wr_idx = 4'd12; wr_frame0 = 32'h0C00_0000;
        tick("R11 overwrite same cycle");
        wr_en = 0;
        tick("R9 R11 overwritten entry");
        lk_req = 0;

        for (int k = 0; k < 60; k++) begin
            logic [31:0] bases [6];
            logic [7:0]  tags [4];
            bases = '{32'h0040_0000, 32'h8000_0000, 32'h0100_0000, 32'h0050_0000,
                      32'h0060_0000, 32'h0070_0000};
            tags  = '{8'd1, 8'd5, 8'd6, 8'd9};
            look(bases[$urandom_range(0, 5)] | ($urandom & 32'h0001_FFFF),
                 tags[$urandom_range(0, 3)], bit'($urandom_range(0, 1)), "R1 mixed pattern");
        end

        rst = 1;
        tick("R10 reset again");
        rst = 0;
        look(32'h0040_0123, 8'd5, 0, "R10 entries cleared");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule